// File: doc/BRIEF.md
# Infrared Receive Byte Queue with Interrupt Flags

This block buffers the run-length bytes produced by an infrared pulse sampler and makes them available to a processor through a small memory-mapped register bus. Each byte from the sampler is pushed into a queue whose depth is a parameter (16 or 64 entries). Software pops the bytes one at a time through a data port. It also reads a status word that reports how many bytes are queued, together with three event flags: overflow, end of packet and data available.

The flags are sticky. Software clears one by writing a 1 to its bit. A single interrupt line is raised while any flag is set whose enable bit is also set. The data-available flag is driven by a programmable threshold: it sets once the fill count exceeds the trigger level that software programs, typically half the depth minus one. A control register gates reception. Dropping its global-enable bit empties the queue. Two configuration registers hold the sampler's input polarity, noise threshold and idle threshold, and drive them out to the sampler.

The bus is a single-cycle handshake. A write takes effect at the clock edge where `bus_valid` and `bus_write` are high. A read returns its data on `bus_rdata` one cycle later, after that same edge.

Top module: `ir_rx_fifo_top`

## Requirements
- R1: After reset the control, enable and status registers read 0, the fill count is 0 and `irq` is low.
- R2: While control bits 0 (global enable) and 1 (receive enable) are both 1, each `smp_valid` cycle stores `smp_byte`. Reading offset 0x20 returns the oldest stored byte in bits 7:0 and removes it. Reading it while empty returns 0 and removes nothing.
- R3: A byte arriving while the queue holds DEPTH bytes is discarded. Status bit 0 (overflow) is set, and the bytes already stored are kept intact and in order.
- R4: Status register 0x30 holds the fill count in a field of log2(DEPTH)+1 bits starting at bit 8.
- R5: Status bit 4 (data available) becomes set when the fill count is greater than the trigger level, which is held in register 0x2C from bit 8 upward in log2(DEPTH) bits.
- R6: A `smp_pkt_end` pulse while reception is enabled sets status bit 1 (packet end). A pulse while reception is disabled sets nothing.
- R7: Writing register 0x30 clears each flag whose bit (0, 1 or 4) is written as 1 and leaves the others unchanged. Writing 0xFF clears all of them.
- R8: `irq` is high one cycle after any status flag is set whose enable bit in 0x2C (same bit positions 0, 1, 4) is 1. Otherwise it is low.
- R9: While control bit 0 is 0 the queue is emptied. While either control bit 0 or bit 1 is 0, arriving bytes are ignored.
- R10: Control 0x00 keeps bits 0, 1, 4 and 5. Register 0x10 keeps bit 2, which drives `cfg_invert`. Register 0x34 keeps bits 15:2, with bits 7:2 driving `cfg_noise` and bits 15:8 driving `cfg_idle`. Every other bit reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sampler byte strobe |
| smp_byte | input | 8 | Sampler run-length byte |
| smp_pkt_end | input | 1 | Sampler end-of-packet pulse |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address of the register |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data |
| irq | output | 1 | Registered interrupt request |
| cfg_invert | output | 1 | Input polarity inversion to the sampler |
| cfg_noise | output | 6 | Noise threshold to the sampler |
| cfg_idle | output | 8 | Idle threshold to the sampler |

## Verification
The queue is swept with every fill level from empty to full, each run with a distinct arithmetic byte pattern. This shows that the order is preserved and that the status count field tracks every level, including the exact-full boundary where a wrap of the pointers would show. The trigger threshold is tried for every level against every fill count, so an off-by-one comparison or a wrong field position cannot pass. Overrun bursts, partial and full flag clears with the interrupt enables set one at a time, and bytes offered with each enable bit dropped separate dropped data from corrupted data. They also separate a sticky flag from a gated interrupt.

// File: rtl/ir_rx_pkg.sv
package ir_rx_pkg;
  localparam int AW = 6;
  localparam int DW = 16;

  localparam logic [AW-1:0] OFS_CTRL  = 6'h00;
  localparam logic [AW-1:0] OFS_RXCFG = 6'h10;
  localparam logic [AW-1:0] OFS_DATA  = 6'h20;
  localparam logic [AW-1:0] OFS_IEN   = 6'h2C;
  localparam logic [AW-1:0] OFS_STAT  = 6'h30;
  localparam logic [AW-1:0] OFS_SCFG  = 6'h34;

  // flag vector order inside the block
  localparam int FL_OVF   = 0;
  localparam int FL_PEND  = 1;
  localparam int FL_AVAIL = 2;
  localparam int NFLAGS   = 3;

  // bit positions in the bus words
  localparam int BP_OVF   = 0;
  localparam int BP_PEND  = 1;
  localparam int BP_AVAIL = 4;
  localparam int BP_FIELD = 8;
endpackage

// File: rtl/ir_rx_fifo_store.sv
module ir_rx_fifo_store #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = PW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          pop_en, wr_en;

  assign empty  = (count == '0);
  assign full   = (count == CW'(DEPTH));
  assign pop_en = pop && !empty;
  assign wr_en  = push && (!full || pop_en);
  assign dout   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_en)  wr_ptr <= wr_ptr + 1'b1;
      if (pop_en) rd_ptr <= rd_ptr + 1'b1;
      case ({wr_en, pop_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/ir_rx_flags.sv
module ir_rx_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_ev,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] en,
  output logic [N-1:0] flags,
  output logic         irq
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) flags[i] <= 1'b0;
      else     flags[i] <= (flags[i] && !clr[i]) || set_ev[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(flags & en);
  end
endmodule

// File: rtl/ir_rx_fifo_top.sv
module ir_rx_fifo_top
  import ir_rx_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = PW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          smp_valid,
  input  logic [7:0]    smp_byte,
  input  logic          smp_pkt_end,
  input  logic          bus_valid,
  input  logic          bus_write,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq,
  output logic          cfg_invert,
  output logic [5:0]    cfg_noise,
  output logic [7:0]    cfg_idle
);
  logic [5:0]        ctrl_q;
  logic              rxcfg_q;
  logic [13:0]       scfg_q;
  logic [NFLAGS-1:0] ien_q;
  logic [PW-1:0]     trig_q;

  logic              rd, wr, gen, accept, push, pop_req, pop_en;
  logic [7:0]        head;
  logic [CW-1:0]     fill_cnt;
  logic              full, empty;
  logic [NFLAGS-1:0] set_ev, clr, flags;
  logic [DW-1:0]     rmux;

  assign rd      = bus_valid && !bus_write;
  assign wr      = bus_valid && bus_write;
  assign gen     = ctrl_q[0];
  assign accept  = ctrl_q[0] && ctrl_q[1];
  assign push    = smp_valid && accept;
  assign pop_req = rd && (bus_addr == OFS_DATA);
  assign pop_en  = pop_req && !empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      rxcfg_q <= 1'b0;
      scfg_q  <= '0;
      ien_q   <= '0;
      trig_q  <= '0;
    end else if (wr) begin
      case (bus_addr)
        OFS_CTRL:  ctrl_q  <= bus_wdata[5:0] & 6'h33;
        OFS_RXCFG: rxcfg_q <= bus_wdata[2];
        OFS_SCFG:  scfg_q  <= bus_wdata[15:2];
        OFS_IEN: begin
          ien_q[FL_OVF]   <= bus_wdata[BP_OVF];
          ien_q[FL_PEND]  <= bus_wdata[BP_PEND];
          ien_q[FL_AVAIL] <= bus_wdata[BP_AVAIL];
          trig_q          <= bus_wdata[BP_FIELD +: PW];
        end
        default: ;
      endcase
    end
  end

  assign cfg_invert = rxcfg_q;
  assign cfg_noise  = scfg_q[5:0];
  assign cfg_idle   = scfg_q[13:6];

  ir_rx_fifo_store #(.DEPTH(DEPTH), .W(8)) u_store (
    .clk   (clk),
    .rst   (rst),
    .flush (!gen),
    .push  (push),
    .din   (smp_byte),
    .pop   (pop_req),
    .dout  (head),
    .count (fill_cnt),
    .full  (full),
    .empty (empty)
  );

  always_comb begin
    set_ev           = '0;
    set_ev[FL_OVF]   = push && full && !pop_en;
    set_ev[FL_PEND]  = smp_pkt_end && accept;
    set_ev[FL_AVAIL] = fill_cnt > {1'b0, trig_q};
    clr              = '0;
    if (wr && bus_addr == OFS_STAT) begin
      clr[FL_OVF]   = bus_wdata[BP_OVF];
      clr[FL_PEND]  = bus_wdata[BP_PEND];
      clr[FL_AVAIL] = bus_wdata[BP_AVAIL];
    end
  end

  ir_rx_flags #(.N(NFLAGS)) u_flags (
    .clk    (clk),
    .rst    (rst),
    .set_ev (set_ev),
    .clr    (clr),
    .en     (ien_q),
    .flags  (flags),
    .irq    (irq)
  );

  always_comb begin
    rmux = '0;
    case (bus_addr)
      OFS_CTRL:  rmux[5:0]  = ctrl_q;
      OFS_RXCFG: rmux[2]    = rxcfg_q;
      OFS_SCFG:  rmux[15:2] = scfg_q;
      OFS_DATA:  rmux[7:0]  = empty ? 8'h00 : head;
      OFS_IEN: begin
        rmux[BP_OVF]         = ien_q[FL_OVF];
        rmux[BP_PEND]        = ien_q[FL_PEND];
        rmux[BP_AVAIL]       = ien_q[FL_AVAIL];
        rmux[BP_FIELD +: PW] = trig_q;
      end
      OFS_STAT: begin
        rmux[BP_OVF]         = flags[FL_OVF];
        rmux[BP_PEND]        = flags[FL_PEND];
        rmux[BP_AVAIL]       = flags[FL_AVAIL];
        rmux[BP_FIELD +: CW] = fill_cnt;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     bus_rdata <= '0;
    else if (rd) bus_rdata <= rmux;
  end
endmodule

module ir_rx_fifo_chk #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst,
  input logic          gen,
  input logic          accept,
  input logic          smp_valid,
  input logic          smp_pkt_end,
  input logic          full,
  input logic          pop_en,
  input logic [CW-1:0] fill_cnt,
  input logic [2:0]    flags,
  input logic [2:0]    ien,
  input logic          irq
);
  assert_count_bound_R4: assert property (@(posedge clk) disable iff (rst)
    fill_cnt <= CW'(DEPTH));
  assert_drop_sets_ovf_R3: assert property (@(posedge clk) disable iff (rst)
    (accept && smp_valid && full && !pop_en) |=> flags[0]);
  assert_full_holds_count_R3: assert property (@(posedge clk) disable iff (rst)
    (accept && smp_valid && full && !pop_en) |=> fill_cnt == CW'(DEPTH));
  assert_push_grows_R2: assert property (@(posedge clk) disable iff (rst)
    (accept && smp_valid && !full && !pop_en) |=> fill_cnt == $past(fill_cnt) + 1'b1);
  assert_pkt_end_R6: assert property (@(posedge clk) disable iff (rst)
    (accept && smp_pkt_end) |=> flags[1]);
  assert_flush_R9: assert property (@(posedge clk) disable iff (rst)
    !gen |=> fill_cnt == '0);
  assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    ((flags & ien) == 3'b000) |=> !irq);
endmodule

bind ir_rx_fifo_top ir_rx_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .gen         (gen),
  .accept      (accept),
  .smp_valid   (smp_valid),
  .smp_pkt_end (smp_pkt_end),
  .full        (full),
  .pop_en      (pop_en),
  .fill_cnt    (fill_cnt),
  .flags       (flags),
  .ien         (ien_q),
  .irq         (irq)
);

// File: tb/tb_ir_rx_fifo_top.sv
module tb_ir_rx_fifo_top;
  localparam int DEPTH = 16;
  localparam int CW    = $clog2(DEPTH) + 1;

  logic        clk = 1'b0, rst = 1'b1;
  logic        smp_valid = 1'b0, smp_pkt_end = 1'b0;
  logic [7:0]  smp_byte = '0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq, cfg_invert;
  logic [5:0]  cfg_noise;
  logic [7:0]  cfg_idle;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ir_rx_fifo_top #(.DEPTH(DEPTH)) dut (.*);

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output int d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    d = int'(bus_rdata);
  endtask

  task automatic push_bytes(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      smp_valid = 1'b1; smp_byte = 8'((seed + i * 7) & 8'hFF);
    end
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic pkt_end_pulse();
    @(negedge clk); smp_pkt_end = 1'b1;
    @(negedge clk); smp_pkt_end = 1'b0;
  endtask

  task automatic restart();
    wr(6'h00, 16'h0030);
    wr(6'h00, 16'h0033);
    idle(2);
    wr(6'h30, 16'h00FF);
  endtask

  function automatic int cnt_of(input int s);
    return (s >> 8) & ((1 << CW) - 1);
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : stim
    int v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    rd(6'h30, v); check("R1 status", v, 0);
    rd(6'h00, v); check("R1 ctrl", v, 0);
    rd(6'h2C, v); check("R1 ien", v, 0);
    check("R1 irq", int'(irq), 0);

    // R10 register masks and config outputs
    wr(6'h00, 16'hFFFF); rd(6'h00, v); check("R10 ctrl mask", v, 'h33);
    wr(6'h10, 16'hFFFF); rd(6'h10, v); check("R10 rxcfg mask", v, 'h4);
    check("R10 cfg_invert", int'(cfg_invert), 1);
    wr(6'h34, 16'h1407); rd(6'h34, v); check("R10 scfg mask", v, 'h1404);
    check("R10 cfg_noise", int'(cfg_noise), 1);
    check("R10 cfg_idle", int'(cfg_idle), 20);
    rd(6'h24, v); check("R10 unmapped", v, 0);

    // R2 / R4 sweep over every fill level
    for (int n = 0; n <= DEPTH; n++) begin
      restart();
      push_bytes(n, n * 13);
      rd(6'h30, v); check("R4 count", cnt_of(v), n);
      for (int i = 0; i < n; i++) begin
        rd(6'h20, v); check("R2 data order", v, (n * 13 + i * 7) & 'hFF);
      end
      rd(6'h20, v); check("R2 empty read", v, 0);
      rd(6'h30, v); check("R2 count after drain", cnt_of(v), 0);
    end

    // R3 overflow
    restart();
    push_bytes(DEPTH + 3, 5);
    idle(2);
    rd(6'h30, v);
    check("R3 count stays full", cnt_of(v), DEPTH);
    check("R3 ovf flag", v & 1, 1);
    for (int i = 0; i < DEPTH; i++) begin
      rd(6'h20, v); check("R3 kept bytes", v, (5 + i * 7) & 'hFF);
    end

    // R6 packet end and R7 partial / full clear
    pkt_end_pulse(); idle(1);
    rd(6'h30, v); check("R6 pend flag", (v >> 1) & 1, 1);
    wr(6'h30, 16'h0002); idle(1);
    rd(6'h30, v);
    check("R7 pend cleared", (v >> 1) & 1, 0);
    check("R7 ovf kept", v & 1, 1);
    wr(6'h30, 16'h00FF); idle(1);
    rd(6'h30, v); check("R7 all cleared", v & 'h13, 0);

    // R8 interrupt gating
    wr(6'h2C, 16'h0001);
    restart(); idle(2);
    check("R8 irq idle", int'(irq), 0);
    pkt_end_pulse(); idle(3);
    check("R8 pend masked", int'(irq), 0);
    push_bytes(DEPTH + 1, 0); idle(3);
    check("R8 ovf irq", int'(irq), 1);
    wr(6'h30, 16'h0001); idle(3);
    check("R8 irq after clear", int'(irq), 0);
    wr(6'h2C, 16'h0002); idle(3);
    check("R8 pend enabled", int'(irq), 1);
    wr(6'h30, 16'h00FF); wr(6'h2C, 16'h0000);

    // R5 threshold sweep
    for (int lvl = 0; lvl < DEPTH; lvl++) begin
      wr(6'h2C, 16'(lvl << 8));
      rd(6'h2C, v); check("R5 level field", v, lvl << 8);
      for (int k = 0; k <= DEPTH; k++) begin
        restart();
        push_bytes(k, 1); idle(2);
        rd(6'h30, v); check("R5 avail", (v >> 4) & 1, (k > lvl) ? 1 : 0);
      end
    end

    // R9 enable gating and flush
    restart();
    wr(6'h00, 16'h0001);
    push_bytes(3, 0); pkt_end_pulse(); idle(1);
    rd(6'h30, v);
    check("R9 rx disabled count", cnt_of(v), 0);
    check("R9 rx disabled pend", (v >> 1) & 1, 0);
    wr(6'h00, 16'h0003);
    push_bytes(3, 0);
    rd(6'h30, v); check("R9 enabled count", cnt_of(v), 3);
    wr(6'h00, 16'h0002); idle(1);
    rd(6'h30, v); check("R9 flush", cnt_of(v), 0);
    push_bytes(2, 0);
    rd(6'h30, v); check("R9 gen off ignores", cnt_of(v), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule